// File: doc/BRIEF.md
# Dual-Protocol Parallel Display Bus Controller

This block drives an 8-bit parallel display bus with four control pins. At run time it selects either a strobe scheme with separate active-low read and write strobes, or a scheme with a single active-high enable plus a read/not-write level. Every bus timing step is derived from a programmable divided clock. The block can move one byte on its own, or stream a burst between the panel and a local buffer of 16 words of 32 bits. The buffer is filled and drained through a plain addressed port.

A byte on the bus takes three phases of equal length: setup, strobe and hold. Each phase lasts one divided-clock period. In a burst write the bytes come from the buffer words in turn, and the word pointer wraps through the buffer. A refill pulse tells the feeder each time a word has been fully sent. In a burst read the captured bytes land in the buffer from entry 0 upward. A byte-order mode swaps the two bytes inside each 16-bit half of a word, in both directions. In bypass mode, software drives the four control pins as raw bits.

Top module: `lcdp_ctrl`

## Requirements
- R1: Each of the three phases of a byte lasts N system-clock cycles. N comes from the divider code latched at start: code 0 gives 4, codes 1 to 6 give 2^(code+1) (4, 8, 16, 32, 64, 128), and code 7 gives 128. The strobe is therefore active for exactly N cycles per byte.
- R2: Mode 0 is the separate-strobe scheme, with pin bit 0 = RS, bit 1 = CS, bit 2 = read strobe and bit 3 = write strobe. During a transfer CS is low. The write strobe (for writes) or the read strobe (for reads) is low only in the strobe phase, and the other strobe stays high. bus_oe is high for writes and low for reads.
- R3: Mode 1 is the enable scheme, with bit 2 = enable and bit 3 = read/not-write. During a transfer CS is low, bit 3 is 0 for a write and 1 for a read, and the enable is high only in the strobe phase.
- R4: A read samples bus_in at the clock edge that ends the strobe phase. A single-byte read places that byte on rd_byte.
- R5: Byte k of a burst uses buffer word k/4 (modulo 16). With swap off it uses bit lane k mod 4, where lane L is bits [8L+7:8L]. With swap on it uses lane (k mod 4) XOR 1. This applies to both writes and reads.
- R6: A burst write sends exactly op_len bytes (1 to 262143) and reads the buffer words cyclically past entry 15. A single write sends op_wbyte once.
- R7: A burst read performs 4*min(op_len,16) byte reads and fills the buffer from entry 0. Entries beyond that are left unchanged.
- R8: refill_req pulses for one cycle after the fourth byte of each word of a burst write. It never pulses for reads or single-byte operations.
- R9: busy rises in the cycle after an accepted start and stays high for exactly 3*N*bytes cycles. A start is ignored while busy, in bypass mode, or for a burst with op_len = 0.
- R10: The manual pin register resets to 4'b1110. Each cycle it clears the bits in byp_clr and then sets the bits in byp_set, so set wins. While byp_en is high, ctrl_pins shows this register, bus_oe follows cfg_dir and bus_out shows op_wbyte.
- R11: Divider, mode, swap, direction and RS level are latched at start. Changing them during a transfer has no effect on it.
- R12: When idle and not in bypass, CS is high and bus_oe is low. In mode 0 both strobes are high. In mode 1 the enable is low and read/not-write is high. RS follows cfg_rs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 3 | Divider code |
| cfg_mode | input | 1 | Strobe scheme: 0 separate strobes, 1 enable plus read/not-write |
| cfg_swap | input | 1 | Swap bytes inside each 16-bit half |
| cfg_dir | input | 1 | 1 write to panel, 0 read from panel |
| cfg_rs | input | 1 | RS level for transfers |
| op_start | input | 1 | Start request |
| op_single | input | 1 | 1 single byte, 0 burst |
| op_len | input | 18 | Burst length: bytes when writing, words when reading |
| op_wbyte | input | 8 | Byte for a single write and for the bypass bus |
| busy | output | 1 | Transfer in progress |
| refill_req | output | 1 | One-cycle pulse when a buffer word has been sent |
| rd_byte | output | 8 | Result of a single-byte read |
| byp_en | input | 1 | Bypass: pins follow the manual register |
| byp_set | input | 4 | Manual pin bits to set |
| byp_clr | input | 4 | Manual pin bits to clear |
| buf_we | input | 1 | Buffer write enable |
| buf_waddr | input | 4 | Buffer write entry |
| buf_wdata | input | 32 | Buffer write word |
| buf_raddr | input | 4 | Buffer read entry |
| buf_rdata | output | 32 | Buffer read word |
| ctrl_pins | output | 4 | RS, CS, strobe/enable, strobe/read-not-write |
| bus_out | output | 8 | Data driven to the panel |
| bus_oe | output | 1 | Data bus output enable |
| bus_in | input | 8 | Data from the panel |

## Verification
The bench keeps the defaults: 16 buffer entries, an 18-bit length and an 8-bit divider counter. Because the buffer is only 16 words deep, a 70-byte burst write runs past entry 15 and exercises the pointer wrap and the refill pulses within a few hundred cycles. Every divider code, including the clamped codes 0 and 7, is affordable on single-byte transfers. A read with op_len of 20 reaches the 16-word cap, while the full 18-bit length range is covered only by the counter width.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // system cycles per bus phase for a divider code
  function automatic logic [7:0] div_ratio(input logic [2:0] code);
    if (code == 3'd0)      return 8'd4;
    else if (code == 3'd7) return 8'd128;
    else                   return 8'd2 << code;
  endfunction

  // bit lane (in bytes) holding byte slot b of a word
  function automatic logic [1:0] lane_of(input logic [1:0] b, input logic swap);
    return swap ? {b[1], ~b[0]} : b;
  endfunction

endpackage

// File: rtl/lcdp_tick.sv
module lcdp_tick #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] ratio,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == ratio - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  // R1: phase counter never passes the latched ratio
  assert_cnt_below_ratio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < ratio));
endmodule

// File: rtl/lcdp_buf.sv
module lcdp_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_waddr,
  input  logic [31:0]   h_wdata,
  input  logic [AW-1:0] h_raddr,
  output logic [31:0]   h_rdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [1:0]    e_lane,
  input  logic [7:0]    e_byte,
  output logic [31:0]   e_rdata
);
  logic [31:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic [31:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent <= '0;
      else begin
        if (h_we && h_waddr == AW'(i)) ent <= h_wdata;
        if (e_we && e_addr == AW'(i))  ent[8*e_lane +: 8] <= e_byte;
      end
    end
    assign rows[i] = ent;
  end

  assign h_rdata = rows[h_raddr];
  assign e_rdata = rows[e_addr];
endmodule

// File: rtl/lcdp_pins.sv
module lcdp_pins (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       byp,
  input  logic [3:0] man,
  input  logic       active,
  input  logic       strobe,
  input  logic       wr,
  input  logic       rs,
  output logic [3:0] pins
);
  always_comb begin
    if (byp) pins = man;
    else begin
      pins[0] = rs;
      pins[1] = ~active;
      if (!mode) begin
        pins[2] = ~(strobe & ~wr);
        pins[3] = ~(strobe & wr);
      end else begin
        pins[2] = strobe;
        pins[3] = active ? ~wr : 1'b1;
      end
    end
  end

  // R2: chip select is low whenever an engine strobe is out
  assert_cs_low_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && strobe) |-> !pins[1]);

  // R3: read/not-write holds steady while enable stays high
  assert_rw_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && mode && pins[2] && $past(!byp && mode && pins[2])) |-> $stable(pins[3]));
endmodule

// File: rtl/lcdp_ctrl.sv
module lcdp_ctrl
  import lcdp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 18,
  parameter int DIV_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_div,
  input  logic             cfg_mode,
  input  logic             cfg_swap,
  input  logic             cfg_dir,
  input  logic             cfg_rs,
  input  logic             op_start,
  input  logic             op_single,
  input  logic [LEN_W-1:0] op_len,
  input  logic [7:0]       op_wbyte,
  output logic             busy,
  output logic             refill_req,
  output logic [7:0]       rd_byte,
  input  logic             byp_en,
  input  logic [3:0]       byp_set,
  input  logic [3:0]       byp_clr,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [31:0]      buf_wdata,
  input  logic [AW-1:0]    buf_raddr,
  output logic [31:0]      buf_rdata,
  output logic [3:0]       ctrl_pins,
  output logic [7:0]       bus_out,
  output logic             bus_oe,
  input  logic [7:0]       bus_in
);
  // bytes moved by a burst read: whole words, capped by the buffer
  function automatic logic [LEN_W-1:0] rd_total(input logic [LEN_W-1:0] n);
    if (n > LEN_W'(DEPTH)) return LEN_W'(DEPTH * 4);
    else                   return n << 2;
  endfunction

  phase_t           ph;
  logic [DIV_W-1:0] ratio_q;
  logic             mode_q, swap_q, wr_q, single_q, rs_q;
  logic [7:0]       wbyte_q;
  logic [LEN_W-1:0] rem, kidx;
  logic [3:0]       man_q;
  logic             tick;

  // named events
  logic ev_accept, ev_strobe_end, ev_byte_done, active, strobe;
  logic [AW-1:0]    word_sel;
  logic [1:0]       lane_sel;
  logic [31:0]      eng_word;
  logic [7:0]       tx_byte;
  logic [LEN_W-1:0] load_cnt;

  assign active        = (ph != PH_IDLE);
  assign strobe        = (ph == PH_STROBE);
  assign busy          = active;
  assign ev_accept     = op_start && !active && !byp_en && (op_single || op_len != '0);
  assign ev_strobe_end = tick && strobe;
  assign ev_byte_done  = tick && (ph == PH_HOLD);
  assign word_sel      = kidx[AW+1:2];
  assign lane_sel      = lane_of(kidx[1:0], swap_q);
  assign tx_byte       = single_q ? wbyte_q : eng_word[8*lane_sel +: 8];
  assign load_cnt      = op_single ? LEN_W'(1) : (cfg_dir ? op_len : rd_total(op_len));

  lcdp_tick #(.CW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .ratio(ratio_q), .tick(tick)
  );

  lcdp_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .h_we(buf_we), .h_waddr(buf_waddr), .h_wdata(buf_wdata),
    .h_raddr(buf_raddr), .h_rdata(buf_rdata),
    .e_we(ev_strobe_end && !wr_q && !single_q), .e_addr(word_sel),
    .e_lane(lane_sel), .e_byte(bus_in), .e_rdata(eng_word)
  );

  lcdp_pins u_pins (
    .clk(clk), .rst_n(rst_n),
    .mode(active ? mode_q : cfg_mode), .byp(byp_en), .man(man_q),
    .active(active), .strobe(strobe), .wr(wr_q),
    .rs(active ? rs_q : cfg_rs), .pins(ctrl_pins)
  );

  assign bus_oe  = byp_en ? cfg_dir : (active && wr_q);
  assign bus_out = byp_en ? op_wbyte : ((active && wr_q) ? tx_byte : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      ratio_q    <= DIV_W'(4);
      mode_q     <= 1'b0;
      swap_q     <= 1'b0;
      wr_q       <= 1'b0;
      single_q   <= 1'b0;
      rs_q       <= 1'b0;
      wbyte_q    <= 8'h00;
      rem        <= '0;
      kidx       <= '0;
      rd_byte    <= 8'h00;
      refill_req <= 1'b0;
      man_q      <= 4'b1110;
    end else begin
      man_q      <= (man_q & ~byp_clr) | byp_set;
      refill_req <= ev_byte_done && wr_q && !single_q && (kidx[1:0] == 2'd3);
      if (ev_strobe_end && !wr_q && single_q) rd_byte <= bus_in;
      unique case (ph)
        PH_IDLE: if (ev_accept) begin
          ph       <= PH_SETUP;
          ratio_q  <= DIV_W'(div_ratio(cfg_div));
          mode_q   <= cfg_mode;
          swap_q   <= cfg_swap;
          wr_q     <= cfg_dir;
          single_q <= op_single;
          rs_q     <= cfg_rs;
          wbyte_q  <= op_wbyte;
          rem      <= load_cnt;
          kidx     <= '0;
        end
        PH_SETUP:  if (tick) ph <= PH_STROBE;
        PH_STROBE: if (tick) ph <= PH_HOLD;
        PH_HOLD: if (tick) begin
          rem  <= rem - LEN_W'(1);
          kidx <= kidx + LEN_W'(1);
          ph   <= (rem == LEN_W'(1)) ? PH_IDLE : PH_SETUP;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R9: an accepted start raises busy on the next cycle
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
  // R6: a running transfer always has bytes left
  assert_rem_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem != '0));
  // R1: phases only move on a divider tick
  assert_phase_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph != $past(ph)) && ($past(ph) != PH_IDLE)) |-> $past(tick));
  // R8: refill pulses come only from burst writes
  assert_refill_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> $past(wr_q && !single_q && busy));
  // R10: bypass keeps the engine idle
  assert_bypass_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_en && !busy) |=> !busy);
  // R11: latched settings hold during a transfer
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ratio_q) && $stable(mode_q) && $stable(swap_q) && $stable(wr_q)));
endmodule

// File: tb/lcdp_ctrl_bench.sv
module lcdp_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_div = '0;
  logic cfg_mode = 0, cfg_swap = 0, cfg_dir = 0, cfg_rs = 0;
  logic op_start = 0, op_single = 0;
  logic [17:0] op_len = '0;
  logic [7:0] op_wbyte = '0, bus_in = '0;
  logic byp_en = 0;
  logic [3:0] byp_set = '0, byp_clr = '0;
  logic buf_we = 0;
  logic [3:0] buf_waddr = '0, buf_raddr = '0;
  logic [31:0] buf_wdata = '0;
  wire busy, refill_req, bus_oe;
  wire [7:0] rd_byte, bus_out;
  wire [31:0] buf_rdata;
  wire [3:0] ctrl_pins;

  lcdp_ctrl u_lcdp_ctrl (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0;
  logic [31:0] bmem [16];
  logic [7:0] got [80];
  int nb, run_len, width_bad, pin_bad, busy_cyc, refills, salt;
  logic mon_on = 0, s_prev = 0, s_now;
  logic exp_mode, exp_wr, exp_rs;
  int exp_r;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int ratio_of(input int code);
    if (code == 0) return 4;
    if (code == 7) return 128;
    return 1 << (code + 1);
  endfunction

  function automatic logic [7:0] rmodel(input int k);
    return 8'((k * 29 + salt) & 255);
  endfunction

  function automatic logic [7:0] wexp(input int k, input bit sw);
    logic [31:0] w;
    w = bmem[(k / 4) % 16];
    if (sw) w = {w[23:16], w[31:24], w[7:0], w[15:8]};
    return w[8 * (k % 4) +: 8];
  endfunction

  // panel model and pin monitor
  always @(negedge clk) if (mon_on) begin
    s_now = exp_mode ? ctrl_pins[2] : (!ctrl_pins[2] || !ctrl_pins[3]);
    if (busy) busy_cyc++;
    if (refill_req) refills++;
    if (s_now) begin
      if (!s_prev) begin
        if (nb < 80) got[nb] = bus_out;
        bus_in = rmodel(nb);
        nb++;
        run_len = 1;
      end else run_len++;
      if (ctrl_pins[1] !== 1'b0) pin_bad++;
      if (ctrl_pins[0] !== exp_rs) pin_bad++;
      if (bus_oe !== exp_wr) pin_bad++;
      if (exp_mode && ctrl_pins[3] !== !exp_wr) pin_bad++;
      if (!exp_mode && (exp_wr ? ctrl_pins[2] !== 1'b1 : ctrl_pins[3] !== 1'b1)) pin_bad++;
    end else if (s_prev && run_len != exp_r) width_bad++;
    s_prev = s_now;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      chk(0, "R9", "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_op(input int code, input bit mode, input bit sw, input bit wr,
                        input bit single, input int len, input bit scramble);
    int n, words, t;
    string rq;
    @(negedge clk);
    cfg_div = 3'(code); cfg_mode = mode; cfg_swap = sw; cfg_dir = wr;
    cfg_rs = 1'($urandom % 2); op_single = single; op_len = 18'(len);
    op_wbyte = 8'($urandom); salt = int'($urandom % 256);
    #1;
    exp_mode = mode; exp_wr = wr; exp_rs = cfg_rs; exp_r = ratio_of(code);
    nb = 0; run_len = 0; width_bad = 0; pin_bad = 0; busy_cyc = 0; refills = 0;
    s_prev = 0; mon_on = 1; op_start = 1;
    @(negedge clk); op_start = 0;
    if (scramble) begin
      cfg_div = ~cfg_div; cfg_mode = ~mode; cfg_swap = ~sw; cfg_dir = ~wr;
      cfg_rs = ~exp_rs; op_start = 1;
      @(negedge clk); op_start = 0;
      repeat (3) @(negedge clk);
      cfg_div = 3'(code); cfg_mode = mode; cfg_swap = sw; cfg_dir = wr; cfg_rs = exp_rs;
    end
    t = 0;
    while (busy && t < 100000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    mon_on = 0;
    words = (len > 16) ? 16 : len;
    n = single ? 1 : (wr ? len : words * 4);
    rq = scramble ? "R11" : (single ? "R9" : (wr ? "R6" : "R7"));
    chk(nb == n, rq, "byte count", nb, n);
    chk(width_bad == 0, scramble ? "R11" : "R1", "strobe widths off", width_bad, 0);
    chk(busy_cyc == 3 * exp_r * n, scramble ? "R11" : "R9", "busy cycles", busy_cyc, 3 * exp_r * n);
    chk(pin_bad == 0, mode ? "R3" : "R2", "pin errors", pin_bad, 0);
    chk(refills == ((wr && !single) ? n / 4 : 0), "R8", "refill pulses", refills,
        (wr && !single) ? n / 4 : 0);
    if (wr) begin
      int bad = 0, first = -1;
      for (int k = 0; k < n && k < 80; k++) begin
        logic [7:0] e;
        e = single ? op_wbyte : wexp(k, sw);
        if (got[k] !== e) begin bad++; if (first < 0) first = k; end
      end
      chk(bad == 0, single ? "R6" : (sw ? "R5" : "R6"), "written bytes wrong", bad, 0);
    end else if (single) begin
      chk(rd_byte == rmodel(0), "R4", "single read byte", rd_byte, rmodel(0));
    end else begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] e;
        e = bmem[i];
        if (i < words)
          for (int k = 4 * i; k < 4 * i + 4; k++)
            e[8 * (sw ? ((k % 4) ^ 1) : (k % 4)) +: 8] = rmodel(k);
        @(negedge clk); buf_raddr = 4'(i); #1;
        chk(buf_rdata == e, sw ? "R5" : "R7", $sformatf("buffer entry %0d", i), buf_rdata, e);
        bmem[i] = e;
      end
    end
  endtask

  task automatic fill_buf();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      buf_we = 1; buf_waddr = 4'(i); buf_wdata = $urandom; bmem[i] = buf_wdata;
    end
    @(negedge clk); buf_we = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(busy == 0, "R9", "busy after reset", busy, 0);
    chk(refill_req == 0, "R8", "refill after reset", refill_req, 0);
    chk(ctrl_pins == 4'b1110, "R12", "idle pins mode 0", ctrl_pins, 4'b1110);
    chk(bus_oe == 0, "R12", "idle bus_oe", bus_oe, 0);
    cfg_mode = 1; cfg_rs = 1; #1;
    chk(ctrl_pins == 4'b1011, "R12", "idle pins mode 1", ctrl_pins, 4'b1011);
    cfg_mode = 0; cfg_rs = 0;
    fill_buf();

    for (int c = 0; c < 8; c++) run_op(c, 0, 0, 1, 1, 0, 0);  // R1 every code
    run_op(1, 1, 0, 0, 1, 0, 0);   // R3 R4 single read, enable scheme
    run_op(2, 0, 0, 0, 1, 0, 0);   // R4 separate strobes
    run_op(1, 0, 0, 1, 0, 70, 0);  // R6 wrap past entry 15, R8
    run_op(2, 1, 1, 1, 0, 9, 0);   // R5 swapped write
    run_op(1, 0, 1, 0, 0, 20, 0);  // R7 capped at 16 words, R5
    run_op(1, 1, 0, 0, 0, 3, 0);   // R7 partial read
    fill_buf();
    run_op(1, 0, 0, 1, 0, 6, 1);   // R11 settings changed mid-transfer

    // R9: zero-length burst is ignored
    @(negedge clk); op_single = 0; op_len = 0; cfg_dir = 1; op_start = 1;
    @(negedge clk); op_start = 0;
    @(negedge clk);
    chk(busy == 0, "R9", "zero length start ignored", busy, 0);

    // R10: bypass register and pins
    byp_en = 1; cfg_dir = 1; op_wbyte = 8'h5A; cfg_mode = 1; #1;
    chk(ctrl_pins == 4'b1110, "R10", "bypass reset value", ctrl_pins, 4'b1110);
    chk(bus_oe == 1 && bus_out == 8'h5A, "R10", "bypass bus", {bus_oe, bus_out}, 9'h15A);
    byp_set = 4'b0001; byp_clr = 4'b0100;
    @(negedge clk); byp_set = 4'b0100; byp_clr = 4'b0110; #1;
    chk(ctrl_pins == 4'b1011, "R10", "set and clear", ctrl_pins, 4'b1011);
    @(negedge clk); byp_set = 0; byp_clr = 0; #1;
    chk(ctrl_pins == 4'b1101, "R10", "set wins over clear", ctrl_pins, 4'b1101);
    op_single = 1; op_start = 1;
    @(negedge clk); op_start = 0;
    @(negedge clk); #1;
    chk(busy == 0 && ctrl_pins == 4'b1101, "R10", "start ignored in bypass",
        {busy, ctrl_pins}, 5'b01101);
    cfg_dir = 0; #1;
    chk(bus_oe == 0, "R10", "bypass bus_oe follows direction", bus_oe, 0);
    byp_en = 0; cfg_mode = 0;

    for (int i = 0; i < 8; i++)
      run_op(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom % 4 == 0), int'($urandom % 40) + 1, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule